// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Read Sequencer

This block is the master side of a memory read on a bus where the low address byte and the data byte share the same pins. A request gives it a 16-bit address. It drives the high address byte on dedicated pins and the low byte on the shared pins, and it raises the address-latch strobe so that an external latch can hold the low byte. It then releases the shared pins, raises the read strobe and waits for the memory to report completion on its ready input. It captures the byte on the shared pins, and it reports the byte with a one-clock done pulse.

The request side is a valid/ready handshake. A request is taken on a rising edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the sequencer is idle. A request presented while a cycle runs is not taken and has no effect. The requester applies back-pressure by holding `req_valid` with a stable address until it sees `req_ready`. The response side has no back-pressure: `rsp_done` is a single-clock pulse, and `rsp_data` keeps the captured byte until the next capture. A slow memory holds `mem_rdy` low to add wait states. Each rising edge in the data phase at which `mem_rdy` is low adds one clock.

Top module: `muxbus_rd_ctrl`

## Requirements
- R1: A synchronous active-high reset brings the block to idle: `ale_o`=0, `rd_o`=0, `ad_oe_o`=0, `rsp_done`=0 and `req_ready`=1.
- R2: In the clock after an accepted request, `ale_o`=1 and `ad_oe_o`=1, `ad_o` carries address bits [7:0] and `addr_hi_o` carries address bits [15:8].
- R3: `addr_hi_o` holds the accepted high byte without change from the address phase through the clock that carries `rsp_done`.
- R4: The address phase lasts one clock. It is followed by one turnaround clock with `ale_o`=0, `ad_oe_o`=0 and `rd_o`=0, and then by the data phase with `rd_o`=1 and `ad_oe_o`=0. `ad_oe_o` and `rd_o` are never high together.
- R5: `mem_rdy` is sampled on each rising edge in the data phase. Each edge at which it is low keeps the block in the data phase with `rd_o`=1 for one more clock. At least one data-phase clock occurs even when `mem_rdy` is already high.
- R6: At the first data-phase edge where `mem_rdy` is high, `ad_i` is captured. In the next clock `rsp_done`=1 for exactly one clock, `rsp_data` equals the captured byte, `ale_o`=1 and `rd_o`=0. In the clock after that the block is idle again.
- R7: `req_ready` is low from the accepting edge until the block has returned to idle. A request presented while it is low is ignored: the running cycle keeps its address and its result, and no new address phase follows the done clock.
- R8: With k low samples of `mem_rdy`, `rsp_done` is high in the clock that begins k+3 rising edges after the accepting edge.
- R9: Reads can follow one another back to back. A request held valid in the idle clock after a done clock is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 16 | Address of the requested byte |
| mem_rdy | input | 1 | Memory ready; low adds wait states |
| addr_hi_o | output | 8 | High address byte on dedicated pins |
| ad_o | output | 8 | Value driven onto the shared low byte |
| ad_oe_o | output | 1 | Drive enable for the shared low byte |
| ad_i | input | 8 | Value sensed on the shared low byte |
| ale_o | output | 1 | Address-latch strobe, active high |
| rd_o | output | 1 | Memory-read strobe, active high |
| rsp_data | output | 8 | Captured read data |
| rsp_done | output | 1 | One-clock pulse, read data valid |

## Verification
Reads are run with zero, one and several wait states, so an off-by-one in the ready sampling or a missing minimum data clock shows up as a latency error. The bench drives a filler value on `ad_i` whenever `rd_o` is low, so a capture taken in the wrong clock returns the filler instead of the expected byte. Addresses of all zeros, all ones and mixed patterns separate the high and low byte paths. A request held during a running cycle, followed by back-to-back reads, separates ignored requests from accepted ones.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_TURN = 3'd2,
    PH_DATA = 3'd3,
    PH_END  = 3'd4
  } phase_t;
endpackage

// File: rtl/mbr_seq.sv
module mbr_seq
  import mbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   mem_rdy,
  output logic   req_ready,
  output logic   accept,
  output logic   capture,
  output logic   busy,
  output logic   ale,
  output logic   rd,
  output logic   oe,
  output logic   done
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_valid) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_TURN;
      PH_TURN: phase_d = PH_DATA;
      PH_DATA: if (mem_rdy) phase_d = PH_END;
      PH_END:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (phase_q == PH_DATA) && mem_rdy;
  assign busy      = (phase_q != PH_IDLE);
  assign ale       = (phase_q == PH_ADDR) || (phase_q == PH_END);
  assign oe        = (phase_q == PH_ADDR);
  assign rd        = (phase_q == PH_DATA);
  assign done      = (phase_q == PH_END);

  AST_NO_DRIVE_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    !(oe && rd)); // R4
  AST_ACCEPT_OPENS_ADDR: assert property (@(posedge clk) disable iff (rst)
    accept |=> (ale && oe && !rd)); // R2
  AST_WAIT_STRETCHES: assert property (@(posedge clk) disable iff (rst)
    (rd && !mem_rdy) |=> (rd && !done)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready && !ale)); // R6
  AST_CAPTURE_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    capture |=> done); // R6
endmodule

// File: rtl/mbr_addr_path.sv
module mbr_addr_path #(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   hi,
  output logic [LO_W-1:0]   lo
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= addr_in;
  end

  assign hi = addr_q[ADDR_W-1:LO_W];
  assign lo = addr_q[LO_W-1:0];

  AST_HI_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold)) |-> $stable(hi)); // R3
  AST_NO_LOAD_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    hold |-> !load); // R7
endmodule

// File: rtl/mbr_capture.sv
module mbr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/muxbus_rd_ctrl.sv
module muxbus_rd_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mem_rdy,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done
);
  logic accept, capture, busy;

  mbr_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mem_rdy   (mem_rdy),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .busy      (busy),
    .ale       (ale_o),
    .rd        (rd_o),
    .oe        (ad_oe_o),
    .done      (rsp_done)
  );

  mbr_addr_path #(.ADDR_W(ADDR_W), .LO_W(DATA_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .hold    (busy),
    .addr_in (req_addr),
    .hi      (addr_hi_o),
    .lo      (ad_o)
  );

  mbr_capture #(.W(DATA_W)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .load (capture),
    .din  (ad_i),
    .dout (rsp_data)
  );

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    (rd_o || rsp_done) |-> !req_ready); // R7
  AST_DATA_HELD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (!rd_o && !rsp_done && $past(rsp_done)) |-> $stable(rsp_data)); // R6
endmodule

// File: tb/muxbus_rd_ctrl_tb.sv
module muxbus_rd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        mem_rdy = 1'b0;
  logic [7:0]  addr_hi_o, ad_o, ad_i, rsp_data;
  logic        ad_oe_o, ale_o, rd_o, rsp_done;
  logic [7:0]  mem_byte = 8'h00;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  assign ad_i = rd_o ? mem_byte : 8'hEE;

  muxbus_rd_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_rdy(mem_rdy), .addr_hi_o(addr_hi_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ale_o(ale_o),
    .rd_o(rd_o), .rsp_data(rsp_data), .rsp_done(rsp_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ale", ale_o, 0);
    chk("R1 rd", rd_o, 0);
    chk("R1 oe", ad_oe_o, 0);
    chk("R1 done", rsp_done, 0);
    chk("R1 ready", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One read with a given number of wait states; optional busy poke (R7)
  task automatic do_read(input logic [15:0] a, input int waits,
                         input logic [7:0] d, input bit poke);
    mem_byte = d;
    mem_rdy  = 1'b0;
    req_addr = a;
    req_valid = 1'b1;
    chk("R9 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 ale", ale_o, 1);
    chk("R2 oe", ad_oe_o, 1);
    chk("R2 lo", ad_o, a[7:0]);
    chk("R2 hi", addr_hi_o, a[15:8]);
    chk("R7 ready low", req_ready, 0);
    @(negedge clk);
    chk("R4 turn ale", ale_o, 0);
    chk("R4 turn oe", ad_oe_o, 0);
    chk("R4 turn rd", rd_o, 0);
    if (poke) begin
      req_valid = 1'b1;
      req_addr = ~a;
    end
    @(negedge clk);
    for (int i = 0; i <= waits; i++) begin
      chk("R5 rd in data", rd_o, 1);
      chk("R4 oe off in data", ad_oe_o, 0);
      chk("R8 no early done", rsp_done, 0);
      chk("R3 hi held", addr_hi_o, a[15:8]);
      mem_rdy = (i == waits);
      @(negedge clk);
    end
    mem_rdy = 1'b0;
    chk("R6 done", rsp_done, 1);
    chk("R6 data", rsp_data, d);
    chk("R6 ale high", ale_o, 1);
    chk("R6 rd low", rd_o, 0);
    chk("R3 hi at done", addr_hi_o, a[15:8]);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R6 done single", rsp_done, 0);
    chk("R7 no new addr", ale_o, 0);
    chk("R6 data held", rsp_data, d);
    chk("R6 idle ready", req_ready, 1);
  endtask

  task automatic t_nowait();   do_read(16'hA53C, 0, 8'h71, 1'b0); endtask
  task automatic t_waits();    do_read(16'h1234, 3, 8'hC9, 1'b0); endtask
  task automatic t_onewait();  do_read(16'h0000, 1, 8'hFF, 1'b0); endtask
  task automatic t_ones();     do_read(16'hFFFF, 0, 8'h00, 1'b0); endtask
  task automatic t_busy_poke(); do_read(16'h5AA5, 2, 8'h3E, 1'b1); endtask

  task automatic t_back_to_back();
    do_read(16'h0F80, 0, 8'h11, 1'b0);
    do_read(16'h80F0, 5, 8'h22, 1'b0);
  endtask

  initial begin
    #(20 * 5000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nowait();
    t_waits();
    t_onewait();
    t_ones();
    t_busy_poke();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule